// File: doc/BRIEF.md
# Dual-line four-channel serial audio receiver

This block takes two serial audio data lines that share one bit clock and one word-select line. One line carries the front left and right channels. The other carries the rear left and right channels. The block turns them into four 18-bit two's complement words: front left, front right, rear left and rear right. All four words appear together, and a single strobe marks them once per stereo frame.

The block runs on a system clock that is much faster than the serial bit clock. The bit clock, the word select and both data lines each pass through a two-flop synchronizer. A rising bit-clock edge is detected as an event in the system clock domain, and each data bit is taken on that event.

A word starts one bit clock after the word select changes and is received MSB first. A frame with longer words has its extra trailing bits discarded. A frame with shorter words has its missing low bits filled with zero. The two left words are held until the matching right words are complete, and then the whole set is released at once.

Top module: `quad_serial_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, all four word outputs read zero and `frame_valid` is low until the first released frame.
- R2: Word select low marks the left word and high marks the right word. The `sd_front` line drives `fl_word`/`fr_word` and the `sd_rear` line drives `rl_word`/`rr_word`.
- R3: Data is sampled on rising bit-clock edges. The first bit after a word-select change is bit 17 (the MSB) of the new word, and the following bits fill descending positions.
- R4: In words longer than 18 bits, every bit after the 18th leaves the output word unchanged.
- R5: In words shorter than 18 bits, the unreceived low-order positions read zero.
- R6: `frame_valid` is high for exactly one system clock per frame, in the same cycle that the four words take their new values. Between strobes the words do not change.
- R7: After reset, no frame is released until a left word has been received in full, starting at a word-select transition, followed by a right word.
- R8: Two's complement extremes (0x1FFFF, 0x20000, 0x3FFFF, 0x00000) pass through bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial bit clock (asynchronous) |
| ws | input | 1 | Word select, 0 = left, 1 = right |
| sd_front | input | 1 | Serial data for the front pair |
| sd_rear | input | 1 | Serial data for the rear pair |
| fl_word | output | 18 | Front left word |
| fr_word | output | 18 | Front right word |
| rl_word | output | 18 | Rear left word |
| rr_word | output | 18 | Rear right word |
| frame_valid | output | 1 | One-cycle strobe marking a new aligned set |

## Verification
A bit counter that goes wrong shows up as shifted or zeroed bit positions in the next released frame. That is at most one frame of 36 bit clocks later, and it appears on all four words at once, because both lanes share the counter. A wrong left/right tracking state shows up either as a missing or extra strobe, or as a left word paired with the wrong right word. The bench checks strobe counts per frame, bit-exact words for several word lengths, strobe width, and word stability between strobes.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  // Width of a counter able to hold values 0..n inclusive.
  function automatic int unsigned span_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/qsa_sync.sv
module qsa_sync #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_in,
  output logic [LANES-1:0] sync_out
);
  logic [LANES-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/qsa_frame_ctl.sv
module qsa_frame_ctl
  import audio_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned CNT_W  = span_bits(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             ws_s,
  output logic             bit_ev,
  output logic             ws_flip,
  output logic [CNT_W-1:0] bit_idx,
  output logic             left_done,
  output logic             right_done,
  output logic             frame_valid
);
  localparam logic [CNT_W-1:0] WordLen = CNT_W'(WORD_W);

  logic             sck_d_q, ws_prev_q, started_q, left_seen_q, valid_q;
  logic [CNT_W-1:0] idx_q;
  logic             word_done;

  assign bit_ev     = sck_s & ~sck_d_q;
  assign ws_flip    = bit_ev & (ws_s ^ ws_prev_q);
  assign word_done  = ws_flip & started_q;
  assign left_done  = word_done & ~ws_prev_q;
  assign right_done = word_done & ws_prev_q & left_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d_q     <= 1'b0;
      ws_prev_q   <= 1'b0;
      started_q   <= 1'b0;
      left_seen_q <= 1'b0;
      valid_q     <= 1'b0;
      idx_q       <= '0;
    end else begin
      sck_d_q <= sck_s;
      valid_q <= right_done;
      if (bit_ev) begin
        ws_prev_q <= ws_s;
        if (ws_flip) begin
          started_q <= 1'b1;
          idx_q     <= '0;
        end else if (idx_q < WordLen) begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (left_done)      left_seen_q <= 1'b1;
      else if (word_done) left_seen_q <= 1'b0;
    end
  end

  assign bit_idx     = idx_q;
  assign frame_valid = valid_q;

  // R6: strobe lasts a single cycle
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: nothing is released before alignment to a word-select transition
  a_r7_release_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> started_q);
  // R2: a release follows the right word, as select returns to left
  a_r2_release_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(ws_prev_q) && !ws_prev_q));
  // R3: bit position restarts at the MSB after a select change
  a_r3_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ws_flip |=> (idx_q == '0));
endmodule

// File: rtl/qsa_lane.sv
module qsa_lane
  import audio_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned CNT_W  = span_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_s,
  input  logic              bit_ev,
  input  logic              ws_flip,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              left_done,
  input  logic              right_done,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word
);
  localparam logic [CNT_W-1:0] WordLen = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] TopPos  = CNT_W'(WORD_W - 1);

  // Deposit one serial bit at its MSB-first position; beyond the word it is dropped.
  function automatic logic [WORD_W-1:0] place_bit(input logic [WORD_W-1:0] acc,
                                                  input logic [CNT_W-1:0]  idx,
                                                  input logic              b);
    logic [WORD_W-1:0] r;
    r = acc;
    if (idx < WordLen) r[TopPos - idx] = b;
    return r;
  endfunction

  logic [WORD_W-1:0] acc_q, hold_l_q, out_l_q, out_r_q, acc_next;

  assign acc_next = place_bit(acc_q, bit_idx, sd_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      hold_l_q <= '0;
      out_l_q  <= '0;
      out_r_q  <= '0;
    end else begin
      if (bit_ev) acc_q <= ws_flip ? '0 : acc_next;
      if (left_done) hold_l_q <= acc_next;
      if (right_done) begin
        out_l_q <= hold_l_q;
        out_r_q <= acc_next;
      end
    end
  end

  assign left_word  = out_l_q;
  assign right_word = out_r_q;

  // R6: words hold between releases
  a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !right_done |=> ($stable(out_l_q) && $stable(out_r_q)));
  // R5: each word starts from an all-zero accumulator
  a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ws_flip |=> (acc_q == '0));
endmodule

// File: rtl/quad_serial_audio_rx.sv
module quad_serial_audio_rx
  import audio_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ws,
  input  logic              sd_front,
  input  logic              sd_rear,
  output logic [WORD_W-1:0] fl_word,
  output logic [WORD_W-1:0] fr_word,
  output logic [WORD_W-1:0] rl_word,
  output logic [WORD_W-1:0] rr_word,
  output logic              frame_valid
);
  localparam int unsigned CNT_W   = span_bits(WORD_W);
  localparam int unsigned N_LANES = 2;

  logic [3:0]        raw_in, sync_in;
  logic              bit_ev, ws_flip, left_done, right_done;
  logic [CNT_W-1:0]  bit_idx;
  logic [N_LANES-1:0] lane_sd;
  logic [WORD_W-1:0] lane_l [N_LANES];
  logic [WORD_W-1:0] lane_r [N_LANES];

  assign raw_in = {sd_rear, sd_front, ws, sck};

  qsa_sync #(.LANES(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_in)
  );

  qsa_frame_ctl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sck_s(sync_in[0]), .ws_s(sync_in[1]),
    .bit_ev(bit_ev), .ws_flip(ws_flip), .bit_idx(bit_idx),
    .left_done(left_done), .right_done(right_done), .frame_valid(frame_valid)
  );

  assign lane_sd = sync_in[3:2];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    qsa_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .sd_s(lane_sd[g]), .bit_ev(bit_ev),
      .ws_flip(ws_flip), .bit_idx(bit_idx), .left_done(left_done),
      .right_done(right_done), .left_word(lane_l[g]), .right_word(lane_r[g])
    );
  end

  assign fl_word = lane_l[0];
  assign fr_word = lane_r[0];
  assign rl_word = lane_l[1];
  assign rr_word = lane_r[1];

  // R1: outputs quiet right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!frame_valid && fl_word == '0 && rr_word == '0));
endmodule

// File: tb/test_quad_serial_audio_rx.sv
module test_quad_serial_audio_rx;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ws = 1'b0, sd_front = 1'b0, sd_rear = 1'b0;
  logic [17:0] fl_word, fr_word, rl_word, rr_word;
  logic frame_valid;

  int checks = 0, fails = 0;
  int vcount = 0, wide_cnt = 0, unstable_cnt = 0;
  logic prev_v = 1'b0;
  logic [17:0] snap_fl = '0, snap_fr = '0, snap_rl = '0, snap_rr = '0;

  quad_serial_audio_rx i_quad_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd_front(sd_front), .sd_rear(sd_rear),
    .fl_word(fl_word), .fr_word(fr_word), .rl_word(rl_word), .rr_word(rr_word),
    .frame_valid(frame_valid)
  );

  always #10 clk = ~clk;

  always begin
    repeat (8) @(negedge clk);
    sck = ~sck;
  end

  // Monitor sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid && prev_v) wide_cnt++;
      if (frame_valid) begin
        vcount++;
        snap_fl = fl_word; snap_fr = fr_word; snap_rl = rl_word; snap_rr = rr_word;
      end else if (fl_word != snap_fl || fr_word != snap_fr ||
                   rl_word != snap_rl || rr_word != snap_rr) begin
        unstable_cnt++;
      end
      prev_v = frame_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Restatement of R3/R4/R5: serial position j maps to output bit 17-j, zero if not sent
  function automatic logic [17:0] expect_word(input int n, input logic [31:0] w);
    logic [17:0] r;
    for (int j = 0; j < 18; j++) r[17-j] = (j < n) ? w[31-j] : 1'b0;
    return r;
  endfunction

  task automatic send_frame(input int n, input logic [31:0] wfl, input logic [31:0] wfr,
                            input logic [31:0] wrl, input logic [31:0] wrr,
                            input bit expect_rel, input string tag);
    int v0;
    v0 = vcount;
    for (int k = 0; k < 2 * n; k++) begin
      int j;
      bit right_now, right_next;
      j = k % n;
      right_now  = (k >= n);
      right_next = ((k + 1) >= n) && ((k + 1) < 2 * n);
      @(negedge sck);
      ws       = right_next;
      sd_front = right_now ? wfr[31-j] : wfl[31-j];
      sd_rear  = right_now ? wrr[31-j] : wrl[31-j];
    end
    @(posedge sck);
    repeat (5) @(posedge clk);
    @(negedge clk);
    if (!expect_rel) begin
      chk(vcount == v0, {"R7 no release ", tag}, vcount - v0, 0);
    end else begin
      chk(vcount == v0 + 1, {"R6 one strobe ", tag}, vcount - v0, 1);
      chk(fl_word == expect_word(n, wfl), {"R2/R3 front left ", tag}, fl_word, expect_word(n, wfl));
      chk(fr_word == expect_word(n, wfr), {"R2/R3 front right ", tag}, fr_word, expect_word(n, wfr));
      chk(rl_word == expect_word(n, wrl), {"R2/R3 rear left ", tag}, rl_word, expect_word(n, wrl));
      chk(rr_word == expect_word(n, wrr), {"R2/R3 rear right ", tag}, rr_word, expect_word(n, wrr));
    end
  endtask

  task automatic t_reset();
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!frame_valid, "R1 strobe low in reset", frame_valid, 0);
    chk({fl_word, fr_word, rl_word, rr_word} == '0, "R1 words zero in reset", fl_word | rr_word, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!frame_valid && fr_word == '0 && rl_word == '0, "R1 quiet after release", fr_word, 0);
  endtask

  task automatic t_warmup();
    send_frame(18, 32'hFFFF_C000, 32'hFFFF_C000, 32'hFFFF_C000, 32'hFFFF_C000, 1'b0, "warmup");
  endtask

  task automatic t_basic();
    send_frame(18, {18'h12345, 14'h0}, {18'h2ABCD, 14'h0}, {18'h00F0F, 14'h0}, {18'h3C3C3, 14'h0},
               1'b1, "R3 basic");
  endtask

  task automatic t_extremes();
    send_frame(18, {18'h1FFFF, 14'h0}, {18'h20000, 14'h0}, {18'h3FFFF, 14'h0}, {18'h00000, 14'h0},
               1'b1, "R8 extremes");
  endtask

  task automatic t_long();
    send_frame(24, 32'hDEAD_BEFF, 32'h1234_56FF, 32'h8001_7FFF, 32'h5A5A_5AFF, 1'b1, "R4 long");
  endtask

  task automatic t_short();
    send_frame(16, 32'hFFFF_0000, 32'h8001_0000, 32'h7FFE_0000, 32'hC3A5_0000, 1'b1, "R5 short");
  endtask

  task automatic t_swap();
    send_frame(18, {18'h00001, 14'h0}, {18'h20001, 14'h0}, {18'h3FFFE, 14'h0}, {18'h15555, 14'h0},
               1'b1, "R2 swap");
  endtask

  task automatic t_strobe_props();
    chk(wide_cnt == 0, "R6 strobe width", wide_cnt, 0);
    chk(unstable_cnt == 0, "R6 words stable between strobes", unstable_cnt, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_warmup();
    t_basic();
    t_extremes();
    t_long();
    t_short();
    t_swap();
    t_strobe_props();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule